// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control state machine of a multi-cycle processor that runs a small instruction subset: register-register add/subtract, OR-immediate, load word, store word, branch-if-equal and jump. Every instruction first spends one cycle in a fetch state and one in a decode/register-read state. The sequencer then follows a path that depends on the instruction class. A jump or branch finishes after three cycles, a register-register, OR-immediate or store instruction after four, and a load after five. One memory serves both instruction fetch and data access, and a select output picks which address reaches it.

In each state the block drives a Moore control vector into the datapath. The vector covers the PC write enables, the memory address select, memory and instruction-register writes, register-file destination, write enable and write-data select, the two ALU operand selects, the immediate extension type, the PC source, the branch-target capture and the ALU operation. The opcode input comes from the instruction register and is only looked at in the decode state. A parameter chooses between two ways of producing the control vector: flopped outputs, decoded one cycle early from the next state, or outputs decoded combinationally from the current state. Both choices give the same port timing.

Top module: `mcyc_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the vector is the fetch vector: ir_wr=1, pc_wr=1, addr_data=0, alu_a_reg=0, alu_b_sel=1 (constant 4), alu_op=0 (add), pc_src=0 (ALU result), and every other output 0.
- R2: Opcode 100011 (load) takes five cycles. Cycle 3 gives alu_a_reg=1, alu_b_sel=2 (extended immediate), ext_sign=1, alu_op=0. Cycle 4 gives addr_data=1 only. Cycle 5 gives reg_wr=1, wb_mem=1, dst_rd=0.
- R3: Opcode 101011 (store) takes four cycles. Cycle 3 is the same as load cycle 3. Cycle 4 gives addr_data=1 and mem_wr=1, and then fetch follows.
- R4: Opcode 000000 (register-register) takes four cycles. Cycle 3 gives alu_a_reg=1, alu_b_sel=0 (register B), alu_op=3 (function-field decode). Cycle 4 gives reg_wr=1, dst_rd=1, wb_mem=0.
- R5: Opcode 001101 (OR-immediate) takes four cycles. Cycle 3 gives alu_a_reg=1, alu_b_sel=2, ext_sign=0 (zero extension), alu_op=2 (OR). Cycle 4 gives reg_wr=1, dst_rd=0, wb_mem=0.
- R6: Opcode 000100 (branch-if-equal) takes three cycles. Cycle 3 gives pc_wr_cond=1, pc_src=1 (target register), alu_a_reg=1, alu_b_sel=0, alu_op=1 (subtract).
- R7: Opcode 000010 (jump) takes three cycles. Cycle 3 gives pc_wr=1, pc_src=2 (jump address), and every other output 0.
- R8: For any opcode, the decode cycle (cycle 2) gives tgt_wr=1, alu_a_reg=0, alu_b_sel=3 (immediate shifted left by 2), ext_sign=1, alu_op=0, and every other output 0.
- R9: reg_wr is asserted only in the last cycle of a load, register-register or OR-immediate instruction. It is never asserted for store, branch or jump.
- R10: Any opcode outside the six listed goes from decode straight back to fetch. It asserts no PC, memory or register write.
- R11: The opcode value has no effect in any cycle other than decode.
- R12: mem_wr and reg_wr are never high together. pc_wr and pc_wr_cond are never high together.
- R13: Both settings of REG_OUTPUTS give the same output sequence at every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write, qualified by the ALU zero flag in the datapath |
| addr_data | output | 1 | Memory address select: 0 = PC, 1 = ALU result register |
| mem_wr | output | 1 | Memory write enable |
| ir_wr | output | 1 | Instruction register write enable |
| dst_rd | output | 1 | Register destination: 1 = rd field, 0 = rt field |
| reg_wr | output | 1 | Register file write enable |
| wb_mem | output | 1 | Write-back data: 1 = memory data, 0 = ALU result |
| alu_a_reg | output | 1 | ALU A input: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B input: 0 reg B, 1 constant 4, 2 extended immediate, 3 extended immediate << 2 |
| ext_sign | output | 1 | Immediate extension: 1 = sign, 0 = zero |
| pc_src | output | 2 | PC source: 0 ALU result, 1 target register, 2 jump address |
| tgt_wr | output | 1 | Branch target register capture |
| alu_op | output | 2 | ALU operation: 0 add, 1 subtract, 2 OR, 3 function-field decode |

## Verification
The bench builds two copies of the block side by side. One uses REG_OUTPUTS=1 and the other REG_OUTPUTS=0, and both are checked against the same cycle table and against each other. This puts both the early-decoded flop path and the current-state decode path in reach, including how each behaves under an asynchronous reset in the middle of an instruction. The bench drives random opcode values outside the decode cycle, so a design that samples the opcode in the wrong cycle gets caught.

// File: rtl/mcyc_ctrl_pkg.sv
`timescale 1ns/1ps
package mcyc_ctrl_pkg;

    localparam int OPC_W   = 6;
    localparam int BSEL_W  = 2;
    localparam int PCSRC_W = 2;
    localparam int ALUOP_W = 2;

    localparam logic [OPC_W-1:0] OPC_RR  = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ORI = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_ST  = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_JMP = 6'b000010;

    localparam logic [BSEL_W-1:0] BSEL_REG    = 2'd0;
    localparam logic [BSEL_W-1:0] BSEL_FOUR   = 2'd1;
    localparam logic [BSEL_W-1:0] BSEL_IMM    = 2'd2;
    localparam logic [BSEL_W-1:0] BSEL_IMM_SH = 2'd3;

    localparam logic [PCSRC_W-1:0] PCS_ALU = 2'd0;
    localparam logic [PCSRC_W-1:0] PCS_TGT = 2'd1;
    localparam logic [PCSRC_W-1:0] PCS_JMP = 2'd2;

    localparam logic [ALUOP_W-1:0] AOP_ADD  = 2'd0;
    localparam logic [ALUOP_W-1:0] AOP_SUB  = 2'd1;
    localparam logic [ALUOP_W-1:0] AOP_OR   = 2'd2;
    localparam logic [ALUOP_W-1:0] AOP_FUNC = 2'd3;

    typedef enum logic [2:0] {
        CLS_RR, CLS_ORI, CLS_LD, CLS_ST, CLS_BEQ, CLS_JMP, CLS_BAD
    } icls_e;

    typedef enum logic [3:0] {
        S_FETCH, S_DECODE,
        S_RR_EXE, S_RR_WB,
        S_ORI_EXE, S_ORI_WB,
        S_LD_ADR, S_LD_RD, S_LD_WB,
        S_ST_ADR, S_ST_WR,
        S_BR_CMP, S_JMP
    } cstate_e;

    typedef struct packed {
        logic               pc_wr;
        logic               pc_wr_cond;
        logic               addr_data;
        logic               mem_wr;
        logic               ir_wr;
        logic               dst_rd;
        logic               reg_wr;
        logic               wb_mem;
        logic               a_reg;
        logic [BSEL_W-1:0]  b_sel;
        logic               ext_sign;
        logic [PCSRC_W-1:0] pc_src;
        logic               tgt_wr;
        logic [ALUOP_W-1:0] alu_op;
    } ctl_t;

    localparam ctl_t CTL_FETCH = '{
        pc_wr: 1'b1, pc_wr_cond: 1'b0, addr_data: 1'b0, mem_wr: 1'b0,
        ir_wr: 1'b1, dst_rd: 1'b0, reg_wr: 1'b0, wb_mem: 1'b0,
        a_reg: 1'b0, b_sel: BSEL_FOUR, ext_sign: 1'b0, pc_src: PCS_ALU,
        tgt_wr: 1'b0, alu_op: AOP_ADD
    };

    // Moore decode: control vector of one state
    function automatic ctl_t ctl_of(input cstate_e st);
        ctl_t c;
        c = '0;
        case (st)
            S_FETCH: c = CTL_FETCH;
            S_DECODE: begin
                c.tgt_wr   = 1'b1;
                c.b_sel    = BSEL_IMM_SH;
                c.ext_sign = 1'b1;
                c.alu_op   = AOP_ADD;
            end
            S_RR_EXE: begin
                c.a_reg  = 1'b1;
                c.b_sel  = BSEL_REG;
                c.alu_op = AOP_FUNC;
            end
            S_RR_WB: begin
                c.reg_wr = 1'b1;
                c.dst_rd = 1'b1;
            end
            S_ORI_EXE: begin
                c.a_reg    = 1'b1;
                c.b_sel    = BSEL_IMM;
                c.ext_sign = 1'b0;
                c.alu_op   = AOP_OR;
            end
            S_ORI_WB: c.reg_wr = 1'b1;
            S_LD_ADR, S_ST_ADR: begin
                c.a_reg    = 1'b1;
                c.b_sel    = BSEL_IMM;
                c.ext_sign = 1'b1;
                c.alu_op   = AOP_ADD;
            end
            S_LD_RD: c.addr_data = 1'b1;
            S_LD_WB: begin
                c.reg_wr = 1'b1;
                c.wb_mem = 1'b1;
            end
            S_ST_WR: begin
                c.addr_data = 1'b1;
                c.mem_wr    = 1'b1;
            end
            S_BR_CMP: begin
                c.pc_wr_cond = 1'b1;
                c.pc_src     = PCS_TGT;
                c.a_reg      = 1'b1;
                c.b_sel      = BSEL_REG;
                c.alu_op     = AOP_SUB;
            end
            S_JMP: begin
                c.pc_wr  = 1'b1;
                c.pc_src = PCS_JMP;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mcyc_opdec.sv
`timescale 1ns/1ps
module mcyc_opdec
    import mcyc_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output icls_e            cls
);
    always_comb begin
        case (opcode)
            OPC_RR:  cls = CLS_RR;
            OPC_ORI: cls = CLS_ORI;
            OPC_LD:  cls = CLS_LD;
            OPC_ST:  cls = CLS_ST;
            OPC_BEQ: cls = CLS_BEQ;
            OPC_JMP: cls = CLS_JMP;
            default: cls = CLS_BAD;
        endcase
    end
endmodule

// File: rtl/mcyc_outdec.sv
`timescale 1ns/1ps
module mcyc_outdec
    import mcyc_ctrl_pkg::*;
(
    input  cstate_e st,
    output ctl_t    ctl
);
    always_comb begin
        ctl = ctl_of(st);
    end

    // R12: write-enable exclusivity holds in every decoded vector
    always_comb begin
        a_r12_excl_wr: assert (!(ctl.mem_wr && ctl.reg_wr) && !(ctl.pc_wr && ctl.pc_wr_cond));
    end
endmodule

// File: rtl/mcyc_seq.sv
`timescale 1ns/1ps
module mcyc_seq
    import mcyc_ctrl_pkg::*;
#(
    parameter bit REG_OUTPUTS = 1'b1
)(
    input  logic  clk,
    input  logic  rst_n,
    input  icls_e cls,
    output ctl_t  ctl
);
    typedef struct packed {
        cstate_e st;
        ctl_t    ctl;
    } seq_t;

    seq_t seq_d, seq_q;
    ctl_t ctl_now;

    always_comb begin
        cstate_e nx;
        case (seq_q.st)
            S_FETCH:   nx = S_DECODE;
            S_DECODE: begin
                case (cls)
                    CLS_RR:  nx = S_RR_EXE;
                    CLS_ORI: nx = S_ORI_EXE;
                    CLS_LD:  nx = S_LD_ADR;
                    CLS_ST:  nx = S_ST_ADR;
                    CLS_BEQ: nx = S_BR_CMP;
                    CLS_JMP: nx = S_JMP;
                    default: nx = S_FETCH;
                endcase
            end
            S_RR_EXE:  nx = S_RR_WB;
            S_ORI_EXE: nx = S_ORI_WB;
            S_LD_ADR:  nx = S_LD_RD;
            S_LD_RD:   nx = S_LD_WB;
            S_ST_ADR:  nx = S_ST_WR;
            default:   nx = S_FETCH;
        endcase
        seq_d.st  = nx;
        seq_d.ctl = ctl_of(nx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: S_FETCH, ctl: CTL_FETCH};
        end else begin
            seq_q <= seq_d;
        end
    end

    mcyc_outdec u_now (
        .st  (seq_q.st),
        .ctl (ctl_now)
    );

    generate
        if (REG_OUTPUTS) begin : g_flop_out
            assign ctl = seq_q.ctl;
        end else begin : g_comb_out
            assign ctl = ctl_now;
        end
    endgenerate

    // R13: early-decoded flop copy and current-state decode agree
    a_r13_paths_agree: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.ctl == ctl_now);

    // R10: unknown class in decode returns to fetch
    a_r10_bad_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_DECODE && cls == CLS_BAD) |=> (seq_q.st == S_FETCH));

    // R8: fetch is always followed by decode
    a_r8_fetch_then_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_FETCH) |=> (seq_q.st == S_DECODE));
endmodule

// File: rtl/mcyc_ctrl.sv
`timescale 1ns/1ps
module mcyc_ctrl
    import mcyc_ctrl_pkg::*;
#(
    parameter bit REG_OUTPUTS = 1'b1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OPC_W-1:0]   opcode,
    output logic               pc_wr,
    output logic               pc_wr_cond,
    output logic               addr_data,
    output logic               mem_wr,
    output logic               ir_wr,
    output logic               dst_rd,
    output logic               reg_wr,
    output logic               wb_mem,
    output logic               alu_a_reg,
    output logic [BSEL_W-1:0]  alu_b_sel,
    output logic               ext_sign,
    output logic [PCSRC_W-1:0] pc_src,
    output logic               tgt_wr,
    output logic [ALUOP_W-1:0] alu_op
);
    icls_e cls;
    ctl_t  ctl;

    mcyc_opdec u_dec (
        .opcode (opcode),
        .cls    (cls)
    );

    mcyc_seq #(.REG_OUTPUTS(REG_OUTPUTS)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .cls   (cls),
        .ctl   (ctl)
    );

    assign pc_wr      = ctl.pc_wr;
    assign pc_wr_cond = ctl.pc_wr_cond;
    assign addr_data  = ctl.addr_data;
    assign mem_wr     = ctl.mem_wr;
    assign ir_wr      = ctl.ir_wr;
    assign dst_rd     = ctl.dst_rd;
    assign reg_wr     = ctl.reg_wr;
    assign wb_mem     = ctl.wb_mem;
    assign alu_a_reg  = ctl.a_reg;
    assign alu_b_sel  = ctl.b_sel;
    assign ext_sign   = ctl.ext_sign;
    assign pc_src     = ctl.pc_src;
    assign tgt_wr     = ctl.tgt_wr;
    assign alu_op     = ctl.alu_op;

    // R8: an instruction fetch is followed by the target-capturing decode
    a_r8_dec_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> tgt_wr);

    // R9: register write-back ends the instruction
    a_r9_wb_last: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> ir_wr);

    // R3: memory write ends the store
    a_r3_store_last: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> ir_wr);

    // R6: the branch compare ends the branch
    a_r6_branch_last: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_cond |=> ir_wr);

    // R12: no cycle writes both memory and register file
    a_r12_no_dual_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && reg_wr));
endmodule

// File: tb/mcyc_ctrl_tb_top.sv
`timescale 1ns/1ps
module mcyc_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'd0;
    logic [16:0] vi, vc;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mcyc_ctrl #(.REG_OUTPUTS(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .pc_wr(vi[16]), .pc_wr_cond(vi[15]), .addr_data(vi[14]), .mem_wr(vi[13]),
        .ir_wr(vi[12]), .dst_rd(vi[11]), .reg_wr(vi[10]), .wb_mem(vi[9]),
        .alu_a_reg(vi[8]), .alu_b_sel(vi[7:6]), .ext_sign(vi[5]), .pc_src(vi[4:3]),
        .tgt_wr(vi[2]), .alu_op(vi[1:0])
    );

    mcyc_ctrl #(.REG_OUTPUTS(1'b0)) dut_c (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .pc_wr(vc[16]), .pc_wr_cond(vc[15]), .addr_data(vc[14]), .mem_wr(vc[13]),
        .ir_wr(vc[12]), .dst_rd(vc[11]), .reg_wr(vc[10]), .wb_mem(vc[9]),
        .alu_a_reg(vc[8]), .alu_b_sel(vc[7:6]), .ext_sign(vc[5]), .pc_src(vc[4:3]),
        .tgt_wr(vc[2]), .alu_op(vc[1:0])
    );

    function automatic logic [16:0] mk(input bit pcw, input bit pcc, input bit ad,
        input bit mw, input bit irw, input bit rd, input bit rw, input bit wm,
        input bit sa, input logic [1:0] sb, input bit ex, input logic [1:0] ps,
        input bit tw, input logic [1:0] ao);
        return {pcw, pcc, ad, mw, irw, rd, rw, wm, sa, sb, ex, ps, tw, ao};
    endfunction

    // class codes: 0 rr, 1 ori, 2 load, 3 store, 4 beq, 5 jump, 6 unknown
    function automatic int len_of(input int c);
        case (c)
            0, 1, 3: return 4;
            2:       return 5;
            4, 5:    return 3;
            default: return 2;
        endcase
    endfunction

    function automatic logic [16:0] exp_vec(input int c, input int k);
        if (k == 0) return mk(1,0,0,0,1,0,0,0,0,2'd1,0,2'd0,0,2'd0);
        if (k == 1) return mk(0,0,0,0,0,0,0,0,0,2'd3,1,2'd0,1,2'd0);
        case (c)
            0: return (k == 2) ? mk(0,0,0,0,0,0,0,0,1,2'd0,0,2'd0,0,2'd3)
                               : mk(0,0,0,0,0,1,1,0,0,2'd0,0,2'd0,0,2'd0);
            1: return (k == 2) ? mk(0,0,0,0,0,0,0,0,1,2'd2,0,2'd0,0,2'd2)
                               : mk(0,0,0,0,0,0,1,0,0,2'd0,0,2'd0,0,2'd0);
            2: begin
                if (k == 2) return mk(0,0,0,0,0,0,0,0,1,2'd2,1,2'd0,0,2'd0);
                if (k == 3) return mk(0,0,1,0,0,0,0,0,0,2'd0,0,2'd0,0,2'd0);
                return mk(0,0,0,0,0,0,1,1,0,2'd0,0,2'd0,0,2'd0);
            end
            3: return (k == 2) ? mk(0,0,0,0,0,0,0,0,1,2'd2,1,2'd0,0,2'd0)
                               : mk(0,0,1,1,0,0,0,0,0,2'd0,0,2'd0,0,2'd0);
            4: return mk(0,1,0,0,0,0,0,0,1,2'd0,0,2'd1,0,2'd1);
            default: return mk(1,0,0,0,0,0,0,0,0,2'd0,0,2'd2,0,2'd0);
        endcase
    endfunction

    function automatic string tag_of(input int c, input int k);
        if (k == 0) return "R1 R11";
        if (k == 1) return (c == 6) ? "R10 R8" : "R8";
        case (c)
            0: return "R4 R9";
            1: return "R5 R9";
            2: return "R2 R9";
            3: return "R3 R9";
            4: return "R6 R9";
            default: return "R7 R9";
        endcase
    endfunction

    function automatic logic [5:0] opc_of(input int c);
        case (c)
            0: return 6'b000000;
            1: return 6'b001101;
            2: return 6'b100011;
            3: return 6'b101011;
            4: return 6'b000100;
            5: return 6'b000010;
            default: return 6'b111111;
        endcase
    endfunction

    function automatic bit is_known(input logic [5:0] o);
        for (int i = 0; i < 6; i++) if (opc_of(i) == o) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // runs up to nsteps cycles of one instruction; sampling is at negedge
    task automatic run_instr(input int c, input logic [5:0] opc, input int nsteps);
        int n;
        n = (nsteps < len_of(c)) ? nsteps : len_of(c);
        for (int k = 0; k < n; k++) begin
            chk(tag_of(c, k), vi, exp_vec(c, k));
            chk("R13", vc, vi);
            total++;
            if ((vi[13] && vi[10]) || (vi[16] && vi[15])) begin
                bad++;
                $display("FAIL R12 act=%h exp=exclusive writes", vi);
            end
            if (k <= 1) opcode = opc;
            else        opcode = 6'($urandom);
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        opcode = 6'($urandom);
        #12;
        chk("R1 reset", vi, exp_vec(0, 0));
        chk("R13 reset", vc, exp_vec(0, 0));
        @(negedge clk);
        rst_n = 1'b1;
        // directed: each class once, plus other unknown codes
        for (int c = 0; c <= 6; c++) run_instr(c, opc_of(c), 99);
        run_instr(6, 6'b010101, 99);
        run_instr(2, opc_of(2), 99);
        run_instr(4, opc_of(4), 99);
        // reset in the middle of a load
        run_instr(2, opc_of(2), 3);
        rst_n = 1'b0;
        #1;
        chk("R1 midreset", vi, exp_vec(0, 0));
        chk("R13 midreset", vc, exp_vec(0, 0));
        @(negedge clk);
        rst_n = 1'b1;
        // random instruction mix
        for (int n = 0; n < 120; n++) begin
            int c;
            logic [5:0] o;
            c = int'($urandom_range(0, 6));
            o = opc_of(c);
            if (c == 6) begin
                o = 6'($urandom);
                while (is_known(o)) o = 6'($urandom);
            end
            run_instr(c, o, 99);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule